// File: doc/BRIEF.md
# Compare Action Output Controller

This block owns the level of a single capture/compare output pin. A timer counter elsewhere in the chip supplies a one-cycle time-out pulse. Software or a configuration path loads a 3-bit action code through a write strobe. The code picks what happens to the pin on each later time-out: nothing, set, clear or toggle. The upper half of the code space also forces the pin high or low on the same clock edge that stores the code, which gives the waveform a known starting level.

An enable input qualifies the time-out. While it is low, time-outs have no effect on the pin. The immediate level forced by a code write still applies. A status output reports whether compare operations are active, meaning the block is enabled and holds a non-zero code.

Top module: `cmp_pin_ctl`

## Requirements
- R1: After reset the pin output is low, the stored code is 0 and `cmp_active` is low.
- R2: With code 0 stored, time-outs leave the pin unchanged and `cmp_active` stays low.
- R3: With code 1 stored and the block enabled, every time-out inverts the pin. Writing code 1 does not change the pin.
- R4: Code 2 drives the pin low on each enabled time-out and code 3 drives it high. Writing either code does not change the pin.
- R5: Writing code 4 sets the pin high on the clock edge that stores the code. Each later enabled time-out inverts it.
- R6: Writing code 5 drives the pin low on the clock edge that stores the code. Each later enabled time-out inverts it.
- R7: Writing code 6 sets the pin high on the storing edge, and enabled time-outs then drive it low. Writing code 7 drives the pin low on the storing edge, and enabled time-outs then drive it high.
- R8: When a code write and a time-out arrive in the same cycle, only the write and its immediate level (if any) take effect. The new code acts from the next time-out.
- R9: While `en` is low, time-outs leave the pin unchanged, and a code write still applies its immediate level. `cmp_active` equals `en` AND (stored code not 0).
- R10: In a cycle with neither a write nor a time-out, the pin holds its level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| act_we | input | 1 | Action code write strobe |
| act_val | input | 3 | Action code to store |
| timeout | input | 1 | One-cycle time-out pulse from the counter |
| en | input | 1 | Enables time-out actions |
| pin_out | output | 1 | Compare output pin level |
| cmp_active | output | 1 | High while enabled with a non-zero code |

## Verification
Every one of the eight codes is stored from both starting pin levels. Each is then followed by a train of time-outs, once with the block enabled and once with it disabled. The two starting levels show an immediate force apart from a toggle or a plain hold. The train of three time-outs shows a toggle apart from a one-time set or clear. The disabled pass shows that the enable gates only the time-out side and leaves the immediate level in force. A write that coincides with a time-out shows whether the old code or the new code leaked into that cycle.

// File: rtl/cmp_pin_ctl.sv
module cmp_pin_ctl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       act_we,
  input  logic [2:0] act_val,
  input  logic       timeout,
  input  logic       en,
  output logic       pin_out,
  output logic       cmp_active
);

  logic [2:0] code_q;
  logic       pin_q;
  logic       to_level;

  always_comb begin
    case (code_q)
      3'd1, 3'd4, 3'd5: to_level = ~pin_q;
      3'd2, 3'd6:       to_level = 1'b0;
      3'd3, 3'd7:       to_level = 1'b1;
      default:          to_level = pin_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= 3'd0;
      pin_q  <= 1'b0;
    end else if (act_we) begin
      code_q <= act_val;
      if (act_val[2]) pin_q <= ~act_val[0];
    end else if (timeout && en) begin
      pin_q <= to_level;
    end
  end

  assign pin_out    = pin_q;
  assign cmp_active = en & (code_q != 3'd0);

endmodule

module cmp_pin_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       act_we,
  input logic [2:0] act_val,
  input logic       timeout,
  input logic       en,
  input logic       pin_out,
  input logic       cmp_active,
  input logic [2:0] code_q
);

  p_imm_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    act_we && (act_val == 3'd4 || act_val == 3'd6) |=> pin_out);

  p_imm_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    act_we && (act_val == 3'd5 || act_val == 3'd7) |=> !pin_out);

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !act_we && !timeout |=> $stable(pin_out));

  p_inactive_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !act_we && !cmp_active |=> $stable(pin_out));

  p_toggle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !act_we && timeout && en && (code_q == 3'd1 || code_q == 3'd4 || code_q == 3'd5)
    |=> pin_out != $past(pin_out));

  p_no_imm_low_codes_r8: assert property (@(posedge clk) disable iff (!rst_n)
    act_we && !act_val[2] |=> $stable(pin_out));

  p_zero_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
    act_we && act_val == 3'd0 |=> !cmp_active);

endmodule

bind cmp_pin_ctl cmp_pin_ctl_chk u_chk (.*);

// File: tb/test_cmp_pin_ctl.sv
module test_cmp_pin_ctl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       act_we = 1'b0;
  logic [2:0] act_val = 3'd0;
  logic       timeout = 1'b0;
  logic       en = 1'b0;
  logic       pin_out, cmp_active;

  int  n_tests = 0;
  int  n_fail  = 0;
  bit  m_pin   = 1'b0;
  bit  [2:0] m_code = 3'd0;

  always #4 clk = ~clk;

  cmp_pin_ctl i_cmp_pin_ctl (.*);

  function automatic string req_of(input bit [2:0] c);
    case (c)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2, 3'd3: return "R4";
      3'd4: return "R5";
      3'd5: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check(input string req, input bit exp_pin, input bit exp_act);
    n_tests++;
    if (pin_out !== exp_pin || cmp_active !== exp_act) begin
      n_fail++;
      $display("FAIL %s: pin=%0b act=%0b expected pin=%0b act=%0b",
               req, pin_out, cmp_active, exp_pin, exp_act);
    end
  endtask

  task automatic step(input bit we, input bit [2:0] val, input bit to, input bit e,
                      input string req);
    act_we = we; act_val = val; timeout = to; en = e;
    @(posedge clk);
    @(negedge clk);
    if (we) begin
      m_code = val;
      if (val[2]) m_pin = ~val[0];
    end else if (to && e) begin
      case (m_code)
        3'd1, 3'd4, 3'd5: m_pin = ~m_pin;
        3'd2, 3'd6: m_pin = 1'b0;
        3'd3, 3'd7: m_pin = 1'b1;
        default: ;
      endcase
    end
    check(req, m_pin, e && (m_code != 3'd0));
  endtask

  initial begin
    #(8 * 100000);
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    en = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", 1'b0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", 1'b0, 1'b0);
    step(0, 3'd0, 1, 1, "R2");
    step(0, 3'd0, 0, 1, "R10");

    for (int init = 0; init < 2; init++) begin
      for (int c = 0; c < 8; c++) begin
        for (int e = 0; e < 2; e++) begin
          string rq;
          rq = (e == 0) ? "R9" : req_of(3'(c));
          step(1, init ? 3'd3 : 3'd2, 0, 1, "R4");
          step(0, 3'd0, 1, 1, "R4");
          step(1, 3'(c), 0, e[0], rq);
          for (int k = 0; k < 3; k++) step(0, 3'd0, 1, e[0], rq);
          step(0, 3'd0, 0, e[0], "R10");
          step(1, 3'(c), 1, e[0], "R8");
          step(0, 3'd0, 1, e[0], "R8");
        end
      end
    end

    step(1, 3'd1, 0, 1, "R3");
    step(1, 3'd2, 1, 1, "R8");
    step(0, 3'd0, 1, 1, "R8");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule